// File: doc/BRIEF.md
# Programmable Reload Divider with Toggle Output

This block divides a stream of count events by a programmable ratio and turns the result into a square wave with equal high and low times. An 8-bit down counter is decremented by every count event. When the counter is at zero, the next event reloads it from the `reload_val` input and flips a dedicated output flip-flop. Each half-period of `toggle_out` therefore lasts `reload_val + 1` count events, and a full output period lasts twice that. Typical uses are an alternating drive for a display panel and general clock division.

Count events come from two strobe inputs. One strobe counts on its rising edge and the other on its falling edge. Both strobes are resynchronised into the system clock domain and edge-detected there, so they may be driven from any source that is slower than the system clock. An active-low preset enable loads `reload_val` on the next event in place of a decrement. Two active-low initialise inputs force the output high or low without stopping the counter. `term_cnt` flags the zero state so that it can be wired back to the preset enable.

Top module: `reload_divider`

## Requirements
- R1: A count event occurs for each rising edge of `strobe_rise` and for each falling edge of `strobe_fall`. Each strobe passes through a two-stage synchroniser. After a strobe input changes, `count` changes on the third rising `clk` edge, and not on the first or second.
- R2: If both strobes produce an edge in the same system cycle, only one count event is taken, so `count` moves by one step.
- R3: On a count event with `preset_n` high and `count` not zero, `count` decreases by exactly one.
- R4: On a count event with `count` equal to zero, `count` loads `reload_val` and `toggle_out` inverts. `term_cnt` is 1 exactly when `count` is 0.
- R5: On a count event with `preset_n` low, `count` loads `reload_val`. If `count` was not zero, `toggle_out` does not change.
- R6: With `preset_n` held high and reload value N, `toggle_out` inverts once every N+1 count events. N=0 inverts it on every event, and N=255 inverts it every 256 events.
- R7: While `force_hi_n` is low, `toggle_out` is 1 from the next clock onward. This holds even when `force_lo_n` is also low.
- R8: While `force_lo_n` is low and `force_hi_n` is high, `toggle_out` is 0 from the next clock onward. While either force input is low, `toggle_out` does not toggle, but `count` keeps responding to count events.
- R9: In cycles without a count event, `count` holds its value. `toggle_out` also holds unless a force input is low.
- R10: While `rst_n` is low at a rising `clk` edge, `count` becomes 0 and `toggle_out` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reload_val | input | 8 | Value loaded into the counter on reload or preset |
| preset_n | input | 1 | Preset enable, active low: load on the next event |
| strobe_rise | input | 1 | Count strobe, active on its rising edge |
| strobe_fall | input | 1 | Count strobe, active on its falling edge |
| force_lo_n | input | 1 | Force `toggle_out` low, active low |
| force_hi_n | input | 1 | Force `toggle_out` high, active low, has priority |
| toggle_out | output | 1 | Divided square-wave output |
| count | output | 8 | Current counter value |
| term_cnt | output | 1 | High while the counter is zero |

## Verification
The assertions check the following on every cycle:
- the counter's step rules: decrement, reload at zero, preset load and hold without an event;
- that a reload from zero flips the output;
- the force priority;
- the reset values.

Only the bench's scenarios can show the rest:
- the whole half-period length for reload values 0, 1, 50 and 255, with both strobe types;
- the three-cycle strobe latency;
- that simultaneous edges on the two strobes merge into one event;
- that the counter keeps running while the output is forced.

// File: rtl/reload_divider_pkg.sv
// Package: shared types for the reload divider.
// Assumes: nothing beyond IEEE 1800-2017.
package reload_divider_pkg;
    // Which edge of a strobe counts as an event.
    typedef enum logic {
        EDGE_RISING  = 1'b0,
        EDGE_FALLING = 1'b1
    } edge_sel_e;

    // Priority-resolved drive of the output flip-flop.
    typedef enum logic [1:0] {
        OUT_KEEP   = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_LOW    = 2'd2,
        OUT_HIGH   = 2'd3
    } out_cmd_e;
endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Resynchronises one asynchronous strobe through SYNC_STAGES flip-flops
// and emits a one-cycle pulse for the chosen edge.
// Assumes: SYNC_STAGES >= 2, strobe pulses longer than two clk periods.
module strobe_edge
    import reload_divider_pkg::*;
#(
    parameter int        SYNC_STAGES = 2,
    parameter edge_sel_e EDGE        = EDGE_RISING
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    // Shift the raw strobe into the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], strobe};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[TOP];
    end

    // Select the edge polarity at elaboration.
    generate
        if (EDGE == EDGE_RISING) begin : g_rise
            assign pulse = sync_q[TOP] & ~last_q;
        end else begin : g_fall
            assign pulse = ~sync_q[TOP] & last_q;
        end
    endgenerate

    // R1: a pulse only ever lasts one cycle.
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/down_counter.sv
// Module: down_counter
// Down counter that reloads from reload_val on an event at zero
// or on an event with preset_n low, and decrements otherwise.
// Assumes: evt is a one-cycle pulse in the clk domain.
module down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             preset_n,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt_q;
    logic             load;

    // Reload on zero or on an explicit preset.
    assign load    = !preset_n || (cnt_q == '0);
    assign at_zero = (cnt_q == '0);
    assign count   = cnt_q;

    // Advance the counter on each count event.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (evt)   cnt_q <= load ? reload_val : cnt_q - 1'b1;
    end

    // R3: plain decrement away from zero.
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && preset_n && count != '0) |=> count == CNT_W'($past(count) - 1'b1));
    // R4: reload from zero.
    a_r4_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && count == '0) |=> count == $past(reload_val));
    // R5: preset load.
    a_r5_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !preset_n) |=> count == $past(reload_val));
    // R9: hold without an event.
    a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(count));
    // R10: reset clears the count.
    a_r10_reset_count: assert property (@(posedge clk)
        !rst_n |=> count == '0);
endmodule

// File: rtl/toggle_out_ff.sv
// Module: toggle_out_ff
// Output flip-flop that inverts on a terminal-count event unless a
// force input is active; force-high wins over force-low.
// Assumes: toggle_req is a one-cycle pulse; force inputs are synchronous.
module toggle_out_ff
    import reload_divider_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_req,
    input  logic force_lo_n,
    input  logic force_hi_n,
    output logic q
);
    out_cmd_e cmd;
    logic     q_r;

    // Resolve force priority and the toggle request.
    always_comb begin
        if (!force_hi_n)      cmd = OUT_HIGH;
        else if (!force_lo_n) cmd = OUT_LOW;
        else if (toggle_req)  cmd = OUT_TOGGLE;
        else                  cmd = OUT_KEEP;
    end

    // Update the output register from the resolved command.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else begin
            case (cmd)
                OUT_HIGH:   q_r <= 1'b1;
                OUT_LOW:    q_r <= 1'b0;
                OUT_TOGGLE: q_r <= ~q_r;
                default:    q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

    // R4: an unforced toggle request flips the output.
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_req && force_hi_n && force_lo_n) |=> q != $past(q));
    // R7: force-high, with priority.
    a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        !force_hi_n |=> q);
    // R8: force-low when force-high is idle.
    a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi_n && !force_lo_n) |=> !q);
    // R9: no request, no force: output holds.
    a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_req && force_hi_n && force_lo_n) |=> $stable(q));
    // R10: reset clears the output.
    a_r10_reset_out: assert property (@(posedge clk)
        !rst_n |=> !q);
endmodule

// File: rtl/reload_divider.sv
// Module: reload_divider (top)
// Programmable divider: two edge-detected strobes feed a down counter
// whose zero-state reload flips a square-wave output flip-flop.
// Assumes: one system clock; strobes are asynchronous and slow
// relative to clk; force and preset inputs are synchronous to clk.
module reload_divider
    import reload_divider_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             preset_n,
    input  logic             strobe_rise,
    input  logic             strobe_fall,
    input  logic             force_lo_n,
    input  logic             force_hi_n,
    output logic             toggle_out,
    output logic [CNT_W-1:0] count,
    output logic             term_cnt
);
    logic evt_rise, evt_fall, evt, at_zero;

    strobe_edge #(.SYNC_STAGES(SYNC_STAGES), .EDGE(EDGE_RISING)) u_edge_rise (
        .clk(clk), .rst_n(rst_n), .strobe(strobe_rise), .pulse(evt_rise));

    strobe_edge #(.SYNC_STAGES(SYNC_STAGES), .EDGE(EDGE_FALLING)) u_edge_fall (
        .clk(clk), .rst_n(rst_n), .strobe(strobe_fall), .pulse(evt_fall));

    // Merge coincident edges into a single count event (R2).
    assign evt = evt_rise | evt_fall;

    down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .evt(evt), .preset_n(preset_n),
        .reload_val(reload_val), .count(count), .at_zero(at_zero));

    toggle_out_ff u_out (
        .clk(clk), .rst_n(rst_n), .toggle_req(evt && at_zero),
        .force_lo_n(force_lo_n), .force_hi_n(force_hi_n), .q(toggle_out));

    assign term_cnt = at_zero;

    // R2: coincident edges still give one step.
    a_r2_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rise && evt_fall && preset_n && count != '0)
            |=> count == CNT_W'($past(count) - 1'b1));
endmodule

// File: tb/reload_divider_test.sv
module reload_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reload_val = 8'd0;
    logic       preset_n = 1'b1;
    logic       strobe_rise = 1'b0;
    logic       strobe_fall = 1'b1;
    logic       force_lo_n = 1'b1;
    logic       force_hi_n = 1'b1;
    logic       toggle_out;
    logic [7:0] count;
    logic       term_cnt;

    int checks = 0;
    int fails  = 0;
    int m_cnt;
    logic m_out;

    always #5 clk = ~clk;

    reload_divider uut (
        .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .preset_n(preset_n),
        .strobe_rise(strobe_rise), .strobe_fall(strobe_fall),
        .force_lo_n(force_lo_n), .force_hi_n(force_hi_n),
        .toggle_out(toggle_out), .count(count), .term_cnt(term_cnt));

    // Vector table: reload, strobe type (1 = falling strobe), events,
    // expected final count, expected number of output toggles.
    localparam int NV = 6;
    localparam int V_RELOAD[NV] = '{0, 1, 50, 255, 50, 1};
    localparam int V_FALL[NV]   = '{0, 0, 0, 0, 1, 1};
    localparam int V_EVTS[NV]   = '{5, 6, 103, 258, 60, 4};
    localparam int V_CNT[NV]    = '{0, 0, 50, 254, 42, 0};
    localparam int V_TOG[NV]    = '{5, 3, 3, 2, 2, 2};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One count event on the chosen strobe, with settle time.
    task automatic pulse(input int use_fall);
        if (use_fall != 0) begin
            strobe_fall = 1'b0; wait_clk(4); strobe_fall = 1'b1; wait_clk(4);
        end else begin
            strobe_rise = 1'b1; wait_clk(4); strobe_rise = 1'b0; wait_clk(4);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(1);
        m_cnt = 0; m_out = 1'b0;
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int tog;
        logic prev_out;
        @(negedge clk);
        do_reset();
        // R10: reset state.
        check("R10 count", int'(count), 0);
        check("R10 toggle_out", int'(toggle_out), 0);
        check("R4 term_cnt at zero", int'(term_cnt), 1);

        // R3 R4 R6: table of reload values and strobe types.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            reload_val = 8'(V_RELOAD[v]);
            tog = 0;
            for (int e = 0; e < V_EVTS[v]; e++) begin
                prev_out = toggle_out;
                pulse(V_FALL[v]);
                if (m_cnt == 0) begin m_cnt = V_RELOAD[v]; m_out = ~m_out; end
                else m_cnt = m_cnt - 1;
                if (toggle_out != prev_out) tog++;
                if (int'(count) != m_cnt || toggle_out != m_out) begin
                    check("R3/R4 step count", int'(count), m_cnt);
                    check("R4 step output", int'(toggle_out), int'(m_out));
                end
            end
            check("R6 final count", int'(count), V_CNT[v]);
            check("R6 toggle total", tog, V_TOG[v]);
            check("R4 term_cnt flag", int'(term_cnt), int'(V_CNT[v] == 0));
        end

        // R1: latency of three clock edges.
        do_reset();
        reload_val = 8'd9;
        pulse(0);
        strobe_rise = 1'b1;
        wait_clk(2);
        check("R1 no change after two edges", int'(count), 9);
        wait_clk(1);
        check("R1 change on third edge", int'(count), 8);
        strobe_rise = 1'b0; wait_clk(4);

        // R2: simultaneous edges on both strobes, one step.
        strobe_rise = 1'b1; strobe_fall = 1'b0; wait_clk(4);
        check("R2 merged event", int'(count), 7);
        strobe_rise = 1'b0; strobe_fall = 1'b1; wait_clk(4);
        check("R2 release no event", int'(count), 7);

        // R5: preset in mid-count, output unchanged.
        prev_out = toggle_out;
        reload_val = 8'd20; preset_n = 1'b0;
        pulse(1);
        preset_n = 1'b1;
        check("R5 preset load", int'(count), 20);
        check("R5 output kept", int'(toggle_out), int'(prev_out));
        pulse(0);
        check("R5 decrement after preset", int'(count), 19);

        // R9: idle cycles hold state.
        prev_out = toggle_out;
        wait_clk(20);
        check("R9 count hold", int'(count), 19);
        check("R9 output hold", int'(toggle_out), int'(prev_out));

        // R7 R8: force inputs with priority; counter keeps running.
        reload_val = 8'd0; preset_n = 1'b0; pulse(0); preset_n = 1'b1;
        force_hi_n = 1'b0; force_lo_n = 1'b0; wait_clk(2);
        check("R7 high priority", int'(toggle_out), 1);
        pulse(0); pulse(0);
        check("R8 no toggle while forced", int'(toggle_out), 1);
        check("R8 counter runs while forced", int'(count), 0);
        force_hi_n = 1'b1; wait_clk(2);
        check("R8 force low", int'(toggle_out), 0);
        reload_val = 8'd3; pulse(1);
        check("R8 reload while forced low", int'(count), 3);
        check("R8 still low", int'(toggle_out), 0);
        force_lo_n = 1'b1; wait_clk(2);
        check("R9 output holds after release", int'(toggle_out), 0);
        pulse(1); pulse(1); pulse(1); pulse(1);
        check("R4 toggle after release", int'(toggle_out), 1);
        check("R4 reload after release", int'(count), 3);

        // R10: reset in mid-count.
        pulse(0);
        rst_n = 1'b0; wait_clk(2);
        check("R10 mid-count reset count", int'(count), 0);
        check("R10 mid-count reset output", int'(toggle_out), 0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule